// File: doc/BRIEF.md
# USB OUT Endpoint Transfer Tracker

This block follows one programmed OUT transfer on a single device endpoint of a full-speed USB function controller. Firmware arms the endpoint with a byte budget, a packet budget, the largest packet size, the endpoint kind (isochronous or not) and the frame parity it expects. It then enables the endpoint and lifts the NAK. The packet engine reports each received data packet with its byte length and the parity of the current frame number. For every report the tracker answers with a one-cycle accept or reject pulse, and an accepted packet updates the remaining budgets.

Each accepted packet leaves a data entry in a small receive-status queue. A transfer ends when both budgets run out, or earlier when a packet shorter than the maximum size arrives. On that packet the tracker places a completion entry in the queue, behind the last data entry. When the reader takes that completion entry out, the transfer-complete interrupt goes high and the enable drops. The interrupt is not raised when the entry goes in.

An isochronous endpoint accepts packets only in frames whose parity matches the programmed bit. If such an endpoint still has packets owed when the frame ends, it stops and raises an incomplete-isochronous flag. The remaining byte and packet budgets are always visible on the ports, so firmware can work out how much payload arrived.

Top module: `usb_out_xfer_tracker`

## Requirements
- R1: A synchronous active-high reset clears the enable, both remaining budgets, both interrupt flags and the accept/reject pulses, and leaves the status queue empty.
- R2: A configuration write while the endpoint is disabled loads the byte budget, packet budget, maximum packet size, endpoint kind and frame parity. It sets the enable to the written enable bit and clears both interrupt flags. The new budgets appear on `rem_size` and `rem_pcnt` one cycle later.
- R3: While the endpoint is enabled, a configuration write changes nothing except that a set clear-NAK bit lifts the NAK. The budgets, maximum size, kind, parity and enable keep their values.
- R4: A packet is accepted only when all of these hold: the endpoint is enabled and waiting for data, the NAK has been lifted, the remaining packet budget is nonzero, and the status queue has at least two free slots. Any other packet is rejected and leaves the budgets unchanged.
- R5: An isochronous endpoint rejects a packet whose frame parity differs from the programmed parity bit.
- R6: An accepted packet reduces the remaining packet budget by one. It reduces the remaining byte budget by its length, stopping at zero. It pushes a data entry with kind 0 and the packet length.
- R7: The transfer completes on an accepted packet after which both the byte budget and the packet budget are zero.
- R8: The transfer also completes on an accepted packet whose length is below the maximum packet size, including length 0.
- R9: On completion, a completion entry (kind 1, length 0) is pushed one cycle after the last data entry. From the completing packet until the completion entry is popped, every packet is rejected.
- R10: Popping the completion entry sets `irq_xfer_done` and clears the enable at that same clock edge. Popping a data entry changes neither.
- R11: A frame-end pulse on an enabled, isochronous endpoint that is waiting for data with a nonzero packet budget sets `irq_iso_incomplete` and clears the enable, and no completion entry is pushed. A frame-end pulse on a non-isochronous endpoint has no effect.
- R12: For each cycle with `pkt_valid` high, exactly one of `pkt_ack` or `pkt_nak` is high in the following cycle. Neither pulses otherwise.
- R13: The status queue returns entries in the order they were pushed. `stq_valid` is high whenever it holds an entry.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_wr | input | 1 | Configuration write strobe |
| cfg_enable | input | 1 | Enable bit of the write |
| cfg_clear_nak | input | 1 | Lift-NAK bit of the write |
| cfg_iso | input | 1 | Endpoint is isochronous |
| cfg_odd_frame | input | 1 | Frame parity an isochronous endpoint accepts |
| cfg_size | input | SIZE_W | Transfer byte budget |
| cfg_pcnt | input | PCNT_W | Transfer packet budget |
| cfg_mps | input | LEN_W | Maximum packet size in bytes |
| pkt_valid | input | 1 | Received data packet event |
| pkt_len | input | LEN_W | Byte length of the packet |
| pkt_frame_odd | input | 1 | Bit 0 of the current frame number |
| frame_end | input | 1 | End-of-periodic-frame pulse |
| stq_pop | input | 1 | Remove the head entry of the status queue |
| pkt_ack | output | 1 | Packet accepted (one cycle, registered) |
| pkt_nak | output | 1 | Packet rejected (one cycle, registered) |
| ep_enable | output | 1 | Endpoint enable |
| rem_size | output | SIZE_W | Remaining byte budget |
| rem_pcnt | output | PCNT_W | Remaining packet budget |
| stq_valid | output | 1 | Status queue holds an entry |
| stq_kind | output | 1 | Head entry kind: 0 data, 1 completion |
| stq_len | output | LEN_W | Head entry packet length |
| irq_xfer_done | output | 1 | Transfer-complete interrupt (held until next idle write) |
| irq_iso_incomplete | output | 1 | Isochronous transfer left unfinished at frame end |

## Verification
The bench sweeps transfers of one to four full packets. It also sweeps every short length from 0 to one below the maximum, so that both ways a transfer can finish are exercised. A design that ignores short packets would keep the endpoint enabled and never queue a completion entry. A design that raises the interrupt at push time would have the flag high while data entries are still queued. The bench sends packets with the NAK still in place, in the wrong frame parity, with a zero packet budget, with the queue nearly full, and after completion; a tracker that lets any of these through would move the budgets or answer with an accept. It also checks a byte budget smaller than one packet, where a design without saturation would wrap the counter. Finally, it checks that a frame end aborts only isochronous endpoints, and that a configuration write to a busy endpoint leaves the budgets untouched.

// File: rtl/usb_oxt_pkg.sv
package usb_oxt_pkg;

  // Endpoint control states
  typedef enum logic [1:0] {
    EP_IDLE     = 2'd0,  // disabled
    EP_ARMED    = 2'd1,  // enabled, waiting for data
    EP_FINISH   = 2'd2,  // last packet taken, completion entry goes in next
    EP_WAIT_POP = 2'd3   // completion entry queued, waiting for the reader
  } ep_state_e;

  // Status entry kinds
  localparam logic ENTRY_DATA = 1'b0;
  localparam logic ENTRY_DONE = 1'b1;

endpackage

// File: rtl/oxt_accept_gate.sv
module oxt_accept_gate (
  input  logic pkt_valid,
  input  logic armed,
  input  logic nak_lifted,
  input  logic iso,
  input  logic odd_frame,
  input  logic pkt_frame_odd,
  input  logic pcnt_nz,
  input  logic queue_room,
  output logic accept,
  output logic reject
);

  logic parity_ok;

  always_comb begin
    parity_ok = !iso || (pkt_frame_odd == odd_frame);
    accept    = pkt_valid && armed && nak_lifted && pcnt_nz && queue_room && parity_ok;
    reject    = pkt_valid && !accept;
  end

endmodule

// File: rtl/oxt_xfer_counters.sv
module oxt_xfer_counters #(
  parameter int SIZE_W = 13,
  parameter int PCNT_W = 5,
  parameter int LEN_W  = 11
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [SIZE_W-1:0] load_size,
  input  logic [PCNT_W-1:0] load_pcnt,
  input  logic [LEN_W-1:0]  load_mps,
  input  logic              accept,
  input  logic [LEN_W-1:0]  pkt_len,
  output logic [SIZE_W-1:0] rem_size,
  output logic [PCNT_W-1:0] rem_pcnt,
  output logic              pcnt_nz,
  output logic              ends_xfer
);

  localparam logic [PCNT_W-1:0] PCNT_ONE = PCNT_W'(1);

  logic [LEN_W-1:0]  mps_q;
  logic [SIZE_W-1:0] len_ext;
  logic [SIZE_W-1:0] size_after;
  logic              is_short;
  logic              budgets_out;

  always_comb begin
    len_ext     = SIZE_W'(pkt_len);
    size_after  = (len_ext > rem_size) ? '0 : (rem_size - len_ext);
    is_short    = (pkt_len < mps_q);
    budgets_out = (size_after == '0) && (rem_pcnt == PCNT_ONE);
    ends_xfer   = is_short || budgets_out;
    pcnt_nz     = (rem_pcnt != '0);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rem_size <= '0;
      rem_pcnt <= '0;
      mps_q    <= '0;
    end else if (load) begin
      rem_size <= load_size;
      rem_pcnt <= load_pcnt;
      mps_q    <= load_mps;
    end else if (accept) begin
      rem_size <= size_after;
      rem_pcnt <= rem_pcnt - PCNT_ONE;
    end
  end

endmodule

// File: rtl/oxt_status_fifo.sv
module oxt_status_fifo #(
  parameter int DW    = 12,
  parameter int DEPTH = 8
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          pop,
  output logic          valid,
  output logic [DW-1:0] head,
  output logic          room2
);

  localparam int AW = $clog2(DEPTH);
  localparam logic [AW:0] ROOM_LIMIT = (AW+1)'(DEPTH - 2);

  logic [DW-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [AW:0]   count;
  logic          do_pop;

  always_comb begin
    valid  = (count != '0);
    do_pop = pop && valid;
    head   = mem[rd_ptr];
    room2  = (count <= ROOM_LIMIT);
  end

  // Storage without reset so it maps onto distributed or block RAM
  always_ff @(posedge clk) begin
    if (push) mem[wr_ptr] <= push_data;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push)   wr_ptr <= wr_ptr + 1'b1;
      if (do_pop) rd_ptr <= rd_ptr + 1'b1;
      case ({push, do_pop})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

endmodule

// File: rtl/usb_out_xfer_tracker.sv
module usb_out_xfer_tracker #(
  parameter int SIZE_W  = 13,
  parameter int PCNT_W  = 5,
  parameter int LEN_W   = 11,
  parameter int Q_DEPTH = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cfg_wr,
  input  logic              cfg_enable,
  input  logic              cfg_clear_nak,
  input  logic              cfg_iso,
  input  logic              cfg_odd_frame,
  input  logic [SIZE_W-1:0] cfg_size,
  input  logic [PCNT_W-1:0] cfg_pcnt,
  input  logic [LEN_W-1:0]  cfg_mps,
  input  logic              pkt_valid,
  input  logic [LEN_W-1:0]  pkt_len,
  input  logic              pkt_frame_odd,
  input  logic              frame_end,
  input  logic              stq_pop,
  output logic              pkt_ack,
  output logic              pkt_nak,
  output logic              ep_enable,
  output logic [SIZE_W-1:0] rem_size,
  output logic [PCNT_W-1:0] rem_pcnt,
  output logic              stq_valid,
  output logic              stq_kind,
  output logic [LEN_W-1:0]  stq_len,
  output logic              irq_xfer_done,
  output logic              irq_iso_incomplete
);

  import usb_oxt_pkg::*;

  localparam int ENTRY_W = 1 + LEN_W;

  ep_state_e          state_q, state_d;
  logic               nak_lifted_q;
  logic               iso_q;
  logic               odd_q;
  logic               idle_write;
  logic               accept, reject;
  logic               pcnt_nz, ends_xfer, queue_room;
  logic               last_taken;
  logic               abort_iso;
  logic               done_popped;
  logic               q_push;
  logic [ENTRY_W-1:0] q_push_data;
  logic [ENTRY_W-1:0] q_head;

  always_comb begin
    idle_write = cfg_wr && (state_q == EP_IDLE);
    last_taken = accept && ends_xfer;
    abort_iso  = frame_end && (state_q == EP_ARMED) && iso_q && pcnt_nz && !last_taken;
  end

  oxt_accept_gate gate_i (
    .pkt_valid     (pkt_valid),
    .armed         (state_q == EP_ARMED),
    .nak_lifted    (nak_lifted_q),
    .iso           (iso_q),
    .odd_frame     (odd_q),
    .pkt_frame_odd (pkt_frame_odd),
    .pcnt_nz       (pcnt_nz),
    .queue_room    (queue_room),
    .accept        (accept),
    .reject        (reject)
  );

  oxt_xfer_counters #(
    .SIZE_W (SIZE_W),
    .PCNT_W (PCNT_W),
    .LEN_W  (LEN_W)
  ) cnt_i (
    .clk       (clk),
    .rst       (rst),
    .load      (idle_write),
    .load_size (cfg_size),
    .load_pcnt (cfg_pcnt),
    .load_mps  (cfg_mps),
    .accept    (accept),
    .pkt_len   (pkt_len),
    .rem_size  (rem_size),
    .rem_pcnt  (rem_pcnt),
    .pcnt_nz   (pcnt_nz),
    .ends_xfer (ends_xfer)
  );

  // Data entries go in on acceptance, the completion entry in EP_FINISH;
  // the two never coincide because acceptance needs EP_ARMED.
  always_comb begin
    q_push      = accept || (state_q == EP_FINISH);
    q_push_data = (state_q == EP_FINISH) ? {ENTRY_DONE, {LEN_W{1'b0}}}
                                         : {ENTRY_DATA, pkt_len};
  end

  oxt_status_fifo #(
    .DW    (ENTRY_W),
    .DEPTH (Q_DEPTH)
  ) stq_i (
    .clk       (clk),
    .rst       (rst),
    .push      (q_push),
    .push_data (q_push_data),
    .pop       (stq_pop),
    .valid     (stq_valid),
    .head      (q_head),
    .room2     (queue_room)
  );

  always_comb begin
    stq_kind    = q_head[ENTRY_W-1];
    stq_len     = q_head[LEN_W-1:0];
    done_popped = stq_pop && stq_valid && (stq_kind == ENTRY_DONE);
  end

  always_comb begin
    state_d = state_q;
    case (state_q)
      EP_IDLE:     if (cfg_wr && cfg_enable) state_d = EP_ARMED;
      EP_ARMED: begin
        if (last_taken)     state_d = EP_FINISH;
        else if (abort_iso) state_d = EP_IDLE;
      end
      EP_FINISH:   state_d = EP_WAIT_POP;
      EP_WAIT_POP: if (done_popped) state_d = EP_IDLE;
      default:     state_d = EP_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q            <= EP_IDLE;
      nak_lifted_q       <= 1'b0;
      iso_q              <= 1'b0;
      odd_q              <= 1'b0;
      pkt_ack            <= 1'b0;
      pkt_nak            <= 1'b0;
      ep_enable          <= 1'b0;
      irq_xfer_done      <= 1'b0;
      irq_iso_incomplete <= 1'b0;
    end else begin
      state_q   <= state_d;
      ep_enable <= (state_d != EP_IDLE);
      pkt_ack   <= accept;
      pkt_nak   <= reject;
      if (idle_write) begin
        nak_lifted_q       <= cfg_clear_nak;
        iso_q              <= cfg_iso;
        odd_q              <= cfg_odd_frame;
        irq_xfer_done      <= 1'b0;
        irq_iso_incomplete <= 1'b0;
      end else begin
        if (cfg_wr && cfg_clear_nak) nak_lifted_q <= 1'b1;
        if (done_popped)             irq_xfer_done <= 1'b1;
        if (abort_iso)               irq_iso_incomplete <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/oxt_tracker_checker.sv
module oxt_tracker_checker #(
  parameter int PCNT_W = 5
) (
  input logic              clk,
  input logic              rst,
  input logic              cfg_wr,
  input logic              pkt_valid,
  input logic              pkt_frame_odd,
  input logic              pkt_ack,
  input logic              pkt_nak,
  input logic              ep_enable,
  input logic [PCNT_W-1:0] rem_pcnt,
  input logic              stq_valid,
  input logic              stq_pop,
  input logic              stq_kind,
  input logic              irq_xfer_done,
  input logic              irq_iso_incomplete,
  input logic              iso_q,
  input logic              odd_q,
  input logic [1:0]        state_q
);

  import usb_oxt_pkg::*;

  a_r12_one_response: assert property (@(posedge clk) disable iff (rst)
    pkt_valid |=> (pkt_ack != pkt_nak));

  a_r12_no_spurious: assert property (@(posedge clk) disable iff (rst)
    !pkt_valid |=> (!pkt_ack && !pkt_nak));

  a_r4_reject_keeps_count: assert property (@(posedge clk) disable iff (rst)
    (pkt_nak && !$past(cfg_wr)) |-> $stable(rem_pcnt));

  a_r6_accept_counts_down: assert property (@(posedge clk) disable iff (rst)
    pkt_ack |-> (rem_pcnt == $past(rem_pcnt) - 1'b1));

  a_r5_iso_parity: assert property (@(posedge clk) disable iff (rst)
    pkt_ack |-> (!$past(iso_q) || ($past(pkt_frame_odd) == $past(odd_q))));

  a_r9_accept_only_when_armed: assert property (@(posedge clk) disable iff (rst)
    pkt_ack |-> ($past(state_q) == 2'(EP_ARMED)));

  a_r10_irq_from_done_pop: assert property (@(posedge clk) disable iff (rst)
    $rose(irq_xfer_done) |-> $past(stq_pop && stq_valid && stq_kind));

  a_r10_enable_drop_reason: assert property (@(posedge clk) disable iff (rst)
    $fell(ep_enable) |-> (irq_xfer_done || irq_iso_incomplete));

endmodule

bind usb_out_xfer_tracker oxt_tracker_checker #(
  .PCNT_W (PCNT_W)
) chk_i (
  .clk                (clk),
  .rst                (rst),
  .cfg_wr             (cfg_wr),
  .pkt_valid          (pkt_valid),
  .pkt_frame_odd      (pkt_frame_odd),
  .pkt_ack            (pkt_ack),
  .pkt_nak            (pkt_nak),
  .ep_enable          (ep_enable),
  .rem_pcnt           (rem_pcnt),
  .stq_valid          (stq_valid),
  .stq_pop            (stq_pop),
  .stq_kind           (stq_kind),
  .irq_xfer_done      (irq_xfer_done),
  .irq_iso_incomplete (irq_iso_incomplete),
  .iso_q              (iso_q),
  .odd_q              (odd_q),
  .state_q            (state_q)
);

// File: tb/usb_out_xfer_tracker_tb_top.sv
`timescale 1ns/1ps
module usb_out_xfer_tracker_tb_top;

  localparam int SIZE_W  = 13;
  localparam int PCNT_W  = 5;
  localparam int LEN_W   = 11;
  localparam int Q_DEPTH = 8;

  logic              clk = 1'b0;
  logic              rst;
  logic              cfg_wr, cfg_enable, cfg_clear_nak, cfg_iso, cfg_odd_frame;
  logic [SIZE_W-1:0] cfg_size;
  logic [PCNT_W-1:0] cfg_pcnt;
  logic [LEN_W-1:0]  cfg_mps;
  logic              pkt_valid, pkt_frame_odd, frame_end, stq_pop;
  logic [LEN_W-1:0]  pkt_len;
  logic              pkt_ack, pkt_nak, ep_enable, stq_valid, stq_kind;
  logic [SIZE_W-1:0] rem_size;
  logic [PCNT_W-1:0] rem_pcnt;
  logic [LEN_W-1:0]  stq_len;
  logic              irq_xfer_done, irq_iso_incomplete;

  int checks = 0;
  int fails  = 0;
  int cycles = 0;

  always #4 clk = ~clk;  // 125 MHz

  usb_out_xfer_tracker #(
    .SIZE_W (SIZE_W), .PCNT_W (PCNT_W), .LEN_W (LEN_W), .Q_DEPTH (Q_DEPTH)
  ) dut_i (
    .clk (clk), .rst (rst),
    .cfg_wr (cfg_wr), .cfg_enable (cfg_enable), .cfg_clear_nak (cfg_clear_nak),
    .cfg_iso (cfg_iso), .cfg_odd_frame (cfg_odd_frame),
    .cfg_size (cfg_size), .cfg_pcnt (cfg_pcnt), .cfg_mps (cfg_mps),
    .pkt_valid (pkt_valid), .pkt_len (pkt_len), .pkt_frame_odd (pkt_frame_odd),
    .frame_end (frame_end), .stq_pop (stq_pop),
    .pkt_ack (pkt_ack), .pkt_nak (pkt_nak), .ep_enable (ep_enable),
    .rem_size (rem_size), .rem_pcnt (rem_pcnt),
    .stq_valid (stq_valid), .stq_kind (stq_kind), .stq_len (stq_len),
    .irq_xfer_done (irq_xfer_done), .irq_iso_incomplete (irq_iso_incomplete)
  );

  task automatic check(input string req, input int actual, input int expected);
    checks++;
    if (actual != expected) begin
      fails++;
      $display("FAIL %s: actual=%0d expected=%0d", req, actual, expected);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      checks++;
      fails++;
      $display("FAIL R12 watchdog: actual=%0d expected=%0d", cycles, 100000);
      finish_run();
    end
  end

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic cfg(input int size, input int cnt, input int mps,
                     input bit iso, input bit odd, input bit en, input bit cnak);
    @(negedge clk);
    cfg_wr = 1'b1; cfg_size = SIZE_W'(size); cfg_pcnt = PCNT_W'(cnt);
    cfg_mps = LEN_W'(mps); cfg_iso = iso; cfg_odd_frame = odd;
    cfg_enable = en; cfg_clear_nak = cnak;
    @(negedge clk);
    cfg_wr = 1'b0;
  endtask

  // Returns at the negedge after the edge that took the packet
  task automatic send(input int len, input bit fodd, output bit ack);
    @(negedge clk);
    pkt_valid = 1'b1; pkt_len = LEN_W'(len); pkt_frame_odd = fodd;
    @(negedge clk);
    pkt_valid = 1'b0;
    check("R12 one response", int'(pkt_ack) + int'(pkt_nak), 1);
    ack = pkt_ack;
  endtask

  task automatic pop(output bit valid, output bit kind, output int len);
    @(negedge clk);
    valid = stq_valid; kind = stq_kind; len = int'(stq_len);
    stq_pop = 1'b1;
    @(negedge clk);
    stq_pop = 1'b0;
  endtask

  task automatic pulse_eof();
    @(negedge clk);
    frame_end = 1'b1;
    @(negedge clk);
    frame_end = 1'b0;
  endtask

  initial begin
    bit a, v, k;
    int l;
    rst = 1'b1; cfg_wr = 0; cfg_enable = 0; cfg_clear_nak = 0; cfg_iso = 0;
    cfg_odd_frame = 0; cfg_size = '0; cfg_pcnt = '0; cfg_mps = '0;
    pkt_valid = 0; pkt_len = '0; pkt_frame_odd = 0; frame_end = 0; stq_pop = 0;
    repeat (3) @(negedge clk);
    rst = 1'b0;

    // R1: reset state
    check("R1 enable", int'(ep_enable), 0);
    check("R1 rem_size", int'(rem_size), 0);
    check("R1 rem_pcnt", int'(rem_pcnt), 0);
    check("R1 queue", int'(stq_valid), 0);
    check("R1 irq", int'(irq_xfer_done) + int'(irq_iso_incomplete), 0);
    check("R1 ack", int'(pkt_ack) + int'(pkt_nak), 0);

    // R7, R6, R9, R10, R13: transfers that run both budgets out
    for (int n = 1; n <= 4; n++) begin
      do_reset();
      cfg(n * 8, n, 8, 0, 0, 1, 1);
      check("R2 size load", int'(rem_size), n * 8);
      check("R2 count load", int'(rem_pcnt), n);
      check("R2 enable", int'(ep_enable), 1);
      for (int p = 1; p <= n; p++) begin
        send(8, 0, a);
        check("R6 accept", int'(a), 1);
        check("R6 size", int'(rem_size), (n - p) * 8);
        check("R6 count", int'(rem_pcnt), n - p);
      end
      send(8, 0, a);
      check("R9 reject after finish", int'(a), 0);
      check("R9 count kept", int'(rem_pcnt), 0);
      for (int p = 1; p <= n; p++) begin
        pop(v, k, l);
        check("R13 data valid", int'(v), 1);
        check("R13 data kind", int'(k), 0);
        check("R13 data len", l, 8);
        check("R10 no irq on data pop", int'(irq_xfer_done), 0);
        check("R10 enable kept", int'(ep_enable), 1);
      end
      pop(v, k, l);
      check("R9 done entry", int'(v) * 2 + int'(k), 3);
      check("R9 done len", l, 0);
      check("R10 irq on done pop", int'(irq_xfer_done), 1);
      check("R10 enable cleared", int'(ep_enable), 0);
      check("R13 empty", int'(stq_valid), 0);
    end

    // R8: short packet of every length below the maximum
    do_reset();
    for (int s = 0; s < 8; s++) begin
      cfg(32, 4, 8, 0, 0, 1, 1);
      check("R2 irq cleared", int'(irq_xfer_done), 0);
      send(8, 0, a);
      send(s, 0, a);
      check("R8 short accept", int'(a), 1);
      check("R8 size", int'(rem_size), 24 - s);
      check("R8 count", int'(rem_pcnt), 2);
      pop(v, k, l);
      pop(v, k, l);
      check("R8 short len", l, s);
      pop(v, k, l);
      check("R8 done entry", int'(v) * 2 + int'(k), 3);
      check("R8 enable cleared", int'(ep_enable), 0);
    end

    // R6: byte budget smaller than the packet floors at zero
    do_reset();
    cfg(4, 3, 8, 0, 0, 1, 1);
    send(8, 0, a);
    check("R6 floor size", int'(rem_size), 0);
    check("R6 floor count", int'(rem_pcnt), 2);
    check("R7 not done on size alone", int'(ep_enable), 1);
    send(3, 0, a);
    repeat (2) pop(v, k, l);
    pop(v, k, l);
    check("R8 done after floor", int'(k), 1);

    // R4, R3: NAK not lifted, write while enabled
    do_reset();
    cfg(16, 2, 8, 0, 0, 0, 1);
    send(8, 0, a);
    check("R4 disabled rejects", int'(a), 0);
    cfg(16, 2, 8, 0, 0, 1, 0);
    send(8, 0, a);
    check("R4 NAK held rejects", int'(a), 0);
    check("R4 size kept", int'(rem_size), 16);
    cfg(40, 5, 16, 1, 1, 1, 1);
    check("R3 size kept", int'(rem_size), 16);
    check("R3 count kept", int'(rem_pcnt), 2);
    send(8, 0, a);
    check("R3 NAK lifted accepts", int'(a), 1);
    check("R3 mps kept (not short)", int'(ep_enable), 1);
    check("R3 count after", int'(rem_pcnt), 1);
    send(8, 0, a);
    repeat (2) pop(v, k, l);
    pop(v, k, l);
    check("R7 done", int'(k), 1);

    // R5: isochronous parity gate
    do_reset();
    cfg(16, 2, 8, 1, 1, 1, 1);
    for (int f = 0; f < 4; f++) begin
      send(8, f[0], a);
      check("R5 parity gate", int'(a), f % 2);
      check("R5 count", int'(rem_pcnt), 2 - (f + 1) / 2);
    end
    repeat (2) pop(v, k, l);
    pop(v, k, l);
    check("R5 done entry", int'(k), 1);

    // R11: isochronous frame end with packets owed
    do_reset();
    cfg(16, 2, 8, 1, 0, 1, 1);
    send(8, 0, a);
    pulse_eof();
    check("R11 iso flag", int'(irq_iso_incomplete), 1);
    check("R11 enable cleared", int'(ep_enable), 0);
    check("R11 no done irq", int'(irq_xfer_done), 0);
    pop(v, k, l);
    check("R11 data entry", int'(k), 0);
    check("R11 no done entry", int'(stq_valid), 0);
    cfg(16, 2, 8, 0, 0, 1, 1);
    check("R2 iso flag cleared", int'(irq_iso_incomplete), 0);
    send(8, 0, a);
    pulse_eof();
    check("R11 bulk ignores frame end", int'(ep_enable), 1);
    check("R11 bulk no flag", int'(irq_iso_incomplete), 0);

    // R4: queue room, R1 mid-run reset
    do_reset();
    cfg(200, 20, 8, 0, 0, 1, 1);
    for (int p = 0; p < Q_DEPTH - 1; p++) begin
      send(8, 0, a);
      check("R4 room accept", int'(a), 1);
    end
    send(8, 0, a);
    check("R4 full rejects", int'(a), 0);
    check("R4 count kept", int'(rem_pcnt), 20 - (Q_DEPTH - 1));
    pop(v, k, l);
    send(8, 0, a);
    check("R4 room again", int'(a), 1);
    do_reset();
    check("R1 queue cleared", int'(stq_valid), 0);
    check("R1 enable cleared", int'(ep_enable), 0);

    // R4: zero packet budget
    cfg(0, 0, 8, 0, 0, 1, 1);
    send(0, 0, a);
    check("R4 zero count rejects", int'(a), 0);

    // R12: idle cycles give no pulse
    @(negedge clk);
    check("R12 quiet", int'(pkt_ack) + int'(pkt_nak), 0);

    finish_run();
  end

endmodule